// File: doc/BRIEF.md
# LCD Low-Power Mode Pin Controller

This block sits between a segment LCD waveform generator and the frontplane/backplane pad drivers. In normal operation it passes the generator's pin values through to the pads, but only for pins whose enable bit is set. When a stop or standby request is accepted, it decides what happens to the panel. Waveform generation can keep running. The enabled pins can be driven to ground with the waveform clock halted. Or, when standby coincides with a system power-down, the enabled pins can float.

The block also selects the prescaler reference clock, either the system clock or the oscillator clock. The switch between the two is glitch-free. A watchdog raises a flag when generation is running in a low-power mode but the selected reference clock has stopped toggling, so firmware can detect a missing clock before the panel suffers from DC bias.

Top module: `lcd_lp_pinctl`

## Requirements
- R1: With the module enabled and no low-power request, `pin_oe` equals `pin_en`, `pin_val` equals `gen_val & pin_en`, and `wave_tick_en` follows `presc_tick`. All three are registered and change one clock edge after the inputs are sampled.
- R2: A stop request (`stop_req`=1) accepted while enabled with `run_lp`=0 halts `wave_tick_en`. It sets `pin_val` to 0 and `pin_oe` to the captured mask. `pwr_down` has no influence on stop.
- R3: A stop request accepted while enabled with `run_lp`=1 leaves pin outputs and `wave_tick_en` as in R1.
- R4: A standby request (`stdby_req`=1) with `pwr_down`=0 behaves as in R2 when `run_lp`=0 and as in R3 when `run_lp`=1.
- R5: A standby request with `pwr_down`=1, accepted while enabled, sets every `pin_oe` bit to 0 (high impedance) and halts `wave_tick_en`, whatever the value of `run_lp`.
- R6: While `lcd_en`=0, `pin_oe`, `pin_val` and `wave_tick_en` are all 0 from the next edge on, and a low-power request changes nothing.
- R7: The pin mask used in the grounded state is `pin_en` captured on the cycle the request is accepted. Later changes to `pin_en` do not alter `pin_oe` until exit.
- R8: After a grounded or floating request is released, outputs stay forced until a cycle with `presc_tick`=1. On that edge, pins return to generator control and `wave_tick_en` is asserted together.
- R9: `ref_clk` follows `sys_clk` when `clk_sel`=0 and `osc_clk` when `clk_sel`=1.
- R10: The clock switch is glitch-free. The two source enables are never both active, and no `ref_clk` pulse is shorter than the shorter half-period of the two sources.
- R11: `clk_missing` rises when generation is running in a low-power mode and no `ref_clk` edge has been seen for `timeout_lim` clock cycles. It is 0 in every other state and clears once edges return.
- R12: While `rst` is high and after it, before any request, `pin_oe`, `pin_val`, `wave_tick_en` and `clk_missing` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_clk | input | 1 | System reference clock source |
| osc_clk | input | 1 | Oscillator reference clock source |
| lcd_en | input | 1 | Module enable |
| run_lp | input | 1 | Keep generating in low-power modes |
| clk_sel | input | 1 | Reference select: 0 system, 1 oscillator |
| stop_req | input | 1 | Stop mode request (level) |
| stdby_req | input | 1 | Standby mode request (level) |
| pwr_down | input | 1 | System powers the block down in standby |
| presc_tick | input | 1 | Prescaler tick from the reference divider |
| timeout_lim | input | CNT_W | Missing-clock timeout in clk cycles |
| pin_en | input | NPINS | Per-pin enable mask |
| gen_val | input | NPINS | Waveform generator pin values |
| pin_val | output | NPINS | Pad drive value |
| pin_oe | output | NPINS | Pad output enable (0 = high impedance) |
| wave_tick_en | output | 1 | Gated waveform clock enable |
| ref_clk | output | 1 | Selected reference clock |
| clk_missing | output | 1 | Reference clock lost during low-power run |

## Verification
Pin values, output enables and the tick enable are due one clock edge after the inputs are presented. The bench therefore drives on a falling edge and samples on the following falling edge. The exit test holds the request low for several tickless cycles and checks that the outputs stay forced before the tick arrives. The missing-clock flag is due `timeout_lim` plus a three-flop synchroniser delay after the last reference edge, so the flag is sampled well past that margin in each direction. The reference clock selection is judged by counting `ref_clk` edges over a window many source periods long, after allowing several source cycles for the handover.

// File: rtl/lcd_lp_pkg.sv
package lcd_lp_pkg;
  typedef enum logic [1:0] {
    LP_ACTIVE = 2'd0,
    LP_RUN    = 2'd1,
    LP_GND    = 2'd2,
    LP_FLOAT  = 2'd3
  } lp_mode_e;
endpackage

// File: rtl/lcd_lp_fsm.sv
module lcd_lp_fsm
  import lcd_lp_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lcd_en,
  input  logic             run_lp,
  input  logic             stop_req,
  input  logic             stdby_req,
  input  logic             pwr_down,
  input  logic             presc_tick,
  input  logic [NPINS-1:0] pin_en,
  output lp_mode_e         st_q,
  output lp_mode_e         st_nxt,
  output logic [NPINS-1:0] mask_nxt,
  output logic             wave_tick_en
);
  logic [NPINS-1:0] mask_q;
  logic             lp_req;
  logic             tick_nxt;

  assign lp_req = stop_req | stdby_req;

  always_comb begin
    st_nxt   = st_q;
    mask_nxt = mask_q;
    unique case (st_q)
      LP_ACTIVE: begin
        if (lcd_en && lp_req) begin
          mask_nxt = pin_en;
          if (stdby_req && pwr_down) st_nxt = LP_FLOAT;
          else if (run_lp)           st_nxt = LP_RUN;
          else                       st_nxt = LP_GND;
        end
      end
      LP_RUN: begin
        if (!lp_req) st_nxt = LP_ACTIVE;
      end
      LP_GND, LP_FLOAT: begin
        if (!lp_req && presc_tick) st_nxt = LP_ACTIVE;
      end
      default: st_nxt = LP_ACTIVE;
    endcase
  end

  assign tick_nxt = presc_tick && lcd_en &&
                    ((st_nxt == LP_ACTIVE) || (st_nxt == LP_RUN));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= LP_ACTIVE;
      mask_q       <= '0;
      wave_tick_en <= 1'b0;
    end else begin
      st_q         <= st_nxt;
      mask_q       <= mask_nxt;
      wave_tick_en <= tick_nxt;
    end
  end
endmodule

// File: rtl/lcd_pin_drv.sv
module lcd_pin_drv
  import lcd_lp_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lcd_en,
  input  lp_mode_e         st_nxt,
  input  logic [NPINS-1:0] mask_nxt,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] gen_val,
  output logic [NPINS-1:0] pin_val,
  output logic [NPINS-1:0] pin_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic oe_d, val_d;

    always_comb begin
      oe_d  = 1'b0;
      val_d = 1'b0;
      unique case (st_nxt)
        LP_ACTIVE, LP_RUN: begin
          oe_d  = pin_en[i];
          val_d = gen_val[i] & pin_en[i];
        end
        LP_GND: begin
          oe_d  = mask_nxt[i];
          val_d = 1'b0;
        end
        default: begin
          oe_d  = 1'b0;
          val_d = 1'b0;
        end
      endcase
      if (!lcd_en) begin
        oe_d  = 1'b0;
        val_d = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[i]  <= 1'b0;
        pin_val[i] <= 1'b0;
      end else begin
        pin_oe[i]  <= oe_d;
        pin_val[i] <= val_d;
      end
    end
  end
endmodule

// File: rtl/lcd_refclk_mux.sv
module lcd_refclk_mux (
  input  logic rst,
  input  logic sys_clk,
  input  logic osc_clk,
  input  logic sel_osc,
  output logic sys_on,
  output logic osc_on,
  output logic ref_clk
);
  logic sys_arm, osc_arm;

  // first stage on the rising edge, enable updated on the falling edge
  always_ff @(posedge sys_clk) begin
    if (rst) sys_arm <= 1'b0;
    else     sys_arm <= !sel_osc && !osc_on;
  end
  always_ff @(negedge sys_clk) begin
    if (rst) sys_on <= 1'b0;
    else     sys_on <= sys_arm;
  end

  always_ff @(posedge osc_clk) begin
    if (rst) osc_arm <= 1'b0;
    else     osc_arm <= sel_osc && !sys_on;
  end
  always_ff @(negedge osc_clk) begin
    if (rst) osc_on <= 1'b0;
    else     osc_on <= osc_arm;
  end

  assign ref_clk = (sys_clk & sys_on) | (osc_clk & osc_on);
endmodule

// File: rtl/lcd_clk_watch.sv
module lcd_clk_watch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_clk,
  input  logic             lp_run,
  input  logic [CNT_W-1:0] timeout_lim,
  output logic             clk_missing
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       sync_q;
  logic             edge_seen;
  logic [CNT_W-1:0] idle_cnt;

  assign edge_seen = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q      <= '0;
      idle_cnt    <= '0;
      clk_missing <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], ref_clk};
      if (edge_seen || !lp_run)   idle_cnt <= '0;
      else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
      clk_missing <= lp_run && (idle_cnt >= timeout_lim);
    end
  end
endmodule

// File: rtl/lcd_lp_pinctl.sv
module lcd_lp_pinctl
  import lcd_lp_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_clk,
  input  logic             osc_clk,
  input  logic             lcd_en,
  input  logic             run_lp,
  input  logic             clk_sel,
  input  logic             stop_req,
  input  logic             stdby_req,
  input  logic             pwr_down,
  input  logic             presc_tick,
  input  logic [CNT_W-1:0] timeout_lim,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] gen_val,
  output logic [NPINS-1:0] pin_val,
  output logic [NPINS-1:0] pin_oe,
  output logic             wave_tick_en,
  output logic             ref_clk,
  output logic             clk_missing
);
  lp_mode_e         st_q, st_nxt;
  logic [NPINS-1:0] mask_nxt;
  logic             lp_run;
  logic             sys_on, osc_on;

  assign lp_run = (st_q == LP_RUN);

  lcd_lp_fsm #(.NPINS(NPINS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .lcd_en       (lcd_en),
    .run_lp       (run_lp),
    .stop_req     (stop_req),
    .stdby_req    (stdby_req),
    .pwr_down     (pwr_down),
    .presc_tick   (presc_tick),
    .pin_en       (pin_en),
    .st_q         (st_q),
    .st_nxt       (st_nxt),
    .mask_nxt     (mask_nxt),
    .wave_tick_en (wave_tick_en)
  );

  lcd_pin_drv #(.NPINS(NPINS)) u_drv (
    .clk      (clk),
    .rst      (rst),
    .lcd_en   (lcd_en),
    .st_nxt   (st_nxt),
    .mask_nxt (mask_nxt),
    .pin_en   (pin_en),
    .gen_val  (gen_val),
    .pin_val  (pin_val),
    .pin_oe   (pin_oe)
  );

  lcd_refclk_mux u_mux (
    .rst     (rst),
    .sys_clk (sys_clk),
    .osc_clk (osc_clk),
    .sel_osc (clk_sel),
    .sys_on  (sys_on),
    .osc_on  (osc_on),
    .ref_clk (ref_clk)
  );

  lcd_clk_watch #(.CNT_W(CNT_W)) u_watch (
    .clk         (clk),
    .rst         (rst),
    .ref_clk     (ref_clk),
    .lp_run      (lp_run),
    .timeout_lim (timeout_lim),
    .clk_missing (clk_missing)
  );
endmodule

// File: rtl/lcd_lp_pinctl_chk.sv
module lcd_lp_pinctl_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lcd_en,
  input logic             presc_tick,
  input logic [NPINS-1:0] pin_val,
  input logic [NPINS-1:0] pin_oe,
  input logic             wave_tick_en,
  input logic             lp_run,
  input logic             sys_on,
  input logic             osc_on,
  input logic             clk_missing
);
  assert_idle_hiz_R6: assert property (@(posedge clk) disable iff (rst)
    !lcd_en |=> (pin_oe == '0));

  assert_val_on_driven_R1: assert property (@(posedge clk) disable iff (rst)
    (pin_val & ~pin_oe) == '0);

  assert_tick_from_presc_R8: assert property (@(posedge clk) disable iff (rst)
    wave_tick_en |-> $past(presc_tick));

  assert_tick_needs_enable_R2: assert property (@(posedge clk) disable iff (rst)
    wave_tick_en |-> $past(lcd_en));

  assert_mux_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_on, osc_on}));

  assert_flag_in_run_R11: assert property (@(posedge clk) disable iff (rst)
    clk_missing |-> $past(lp_run));
endmodule

bind lcd_lp_pinctl lcd_lp_pinctl_chk #(.NPINS(NPINS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .lcd_en       (lcd_en),
  .presc_tick   (presc_tick),
  .pin_val      (pin_val),
  .pin_oe       (pin_oe),
  .wave_tick_en (wave_tick_en),
  .lp_run       (lp_run),
  .sys_on       (sys_on),
  .osc_on       (osc_on),
  .clk_missing  (clk_missing)
);

// File: tb/lcd_lp_pinctl_test.sv
module lcd_lp_pinctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS = 8;
  localparam int CNT_W = 8;
  localparam int NVEC  = 8;

  // row: {en, run, stop, stdby, pd, exp_oe[8], exp_val[8], exp_tick, req[4]}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'b10000, 8'hA5, 8'h24, 1'b1, 4'd1},  // R1 active pass-through
    {5'b10100, 8'hA5, 8'h00, 1'b0, 4'd2},  // R2 stop, grounded
    {5'b11100, 8'hA5, 8'h24, 1'b1, 4'd3},  // R3 stop, keeps running
    {5'b10010, 8'hA5, 8'h00, 1'b0, 4'd4},  // R4 standby, grounded
    {5'b11010, 8'hA5, 8'h24, 1'b1, 4'd4},  // R4 standby, keeps running
    {5'b11011, 8'h00, 8'h00, 1'b0, 4'd5},  // R5 standby + power-down floats
    {5'b00100, 8'h00, 8'h00, 1'b0, 4'd6},  // R6 disabled, request ignored
    {5'b10101, 8'hA5, 8'h00, 1'b0, 4'd2}   // R2 power-down ignored on stop
  };

  logic clk = 0, rst = 1, sys_clk = 0, osc_clk = 0, osc_run = 1;
  logic lcd_en = 0, run_lp = 0, clk_sel = 0, stop_req = 0, stdby_req = 0;
  logic pwr_down = 0, presc_tick = 0;
  logic [CNT_W-1:0] timeout_lim = 8'd20;
  logic [NPINS-1:0] pin_en = '0, gen_val = '0;
  logic [NPINS-1:0] pin_val, pin_oe;
  logic wave_tick_en, ref_clk, clk_missing;

  int checks = 0, errors = 0;
  int edge_cnt = 0;
  time t_rise = 0, min_high = 1000000, min_low = 1000000, t_fall = 0;
  logic mon_on = 0;

  lcd_lp_pinctl #(.NPINS(NPINS), .CNT_W(CNT_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always #15 sys_clk = ~sys_clk;
  always begin #35; if (osc_run) osc_clk = ~osc_clk; end

  always @(posedge ref_clk) begin
    edge_cnt++;
    if (mon_on && (t_fall != 0) && ($time - t_fall < min_low)) min_low = $time - t_fall;
    t_rise = $time;
  end
  always @(negedge ref_clk) begin
    if (mon_on && (t_rise != 0) && ($time - t_rise < min_high)) min_high = $time - t_rise;
    t_fall = $time;
  end

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic go_active();
    stop_req = 0; stdby_req = 0; pwr_down = 0; run_lp = 0;
    lcd_en = 1; presc_tick = 1;
    cyc(3);
  endtask

  initial begin
    pin_en = 8'hA5; gen_val = 8'h3C;
    cyc(6);
    // R12: reset state
    check("R12 oe", pin_oe, 0);
    check("R12 val", pin_val, 0);
    check("R12 tick", wave_tick_en, 0);
    check("R12 missing", clk_missing, 0);
    rst = 0;
    cyc(2);
    check("R12 after reset oe", pin_oe, 0);

    for (int v = 0; v < NVEC; v++) begin
      go_active();
      {lcd_en, run_lp, stop_req, stdby_req, pwr_down} = VEC[v][25:21];
      presc_tick = 1;
      cyc(1);
      check($sformatf("R%0d row%0d oe", VEC[v][3:0], v), pin_oe, VEC[v][20:13]);
      check($sformatf("R%0d row%0d val", VEC[v][3:0], v), pin_val, VEC[v][12:5]);
      check($sformatf("R%0d row%0d tick", VEC[v][3:0], v), wave_tick_en, VEC[v][4]);
    end

    // R7: mask captured at entry
    go_active();
    stop_req = 1; cyc(1);
    pin_en = 8'hFF; cyc(3);
    check("R7 mask held", pin_oe, 8'hA5);
    check("R7 val grounded", pin_val, 0);

    // R8: forced until the next prescaler tick
    stop_req = 0; presc_tick = 0; cyc(3);
    check("R8 still forced oe", pin_oe, 8'hA5);
    check("R8 still halted", wave_tick_en, 0);
    presc_tick = 1; cyc(1);
    check("R8 resumed val", pin_val, 8'h3C);
    check("R8 resumed oe", pin_oe, 8'hFF);
    check("R8 resumed tick", wave_tick_en, 1);
    pin_en = 8'hA5;

    // R6: enable dropped while grounded
    stop_req = 1; cyc(2);
    lcd_en = 0; cyc(1);
    check("R6 disable forces hiz", pin_oe, 0);
    lcd_en = 1;

    // R9 / R10: reference clock selection
    go_active();
    mon_on = 1;
    cyc(20);
    edge_cnt = 0; #600;
    check("R9 sys edges", (edge_cnt >= 19 && edge_cnt <= 21), 1);
    clk_sel = 1; cyc(40);
    edge_cnt = 0; #700;
    check("R9 osc edges", (edge_cnt >= 9 && edge_cnt <= 11), 1);
    clk_sel = 0; cyc(40);
    edge_cnt = 0; #600;
    check("R9 back to sys edges", (edge_cnt >= 19 && edge_cnt <= 21), 1);
    clk_sel = 1; cyc(40);
    mon_on = 0;
    check("R10 min high pulse", (min_high >= 15), 1);
    check("R10 min low pulse", (min_low >= 15), 1);

    // R11: missing clock during low-power run
    @(negedge clk);
    stop_req = 1; run_lp = 1; cyc(40);
    check("R11 clock present", clk_missing, 0);
    osc_run = 0; cyc(40);
    check("R11 clock lost", clk_missing, 1);
    osc_run = 1; cyc(20);
    check("R11 clock back", clk_missing, 0);
    osc_run = 0; cyc(40);
    stop_req = 0; cyc(2);
    check("R11 not in run", clk_missing, 0);
    osc_run = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule